// File: doc/BRIEF.md
# Mixed-Semantics Interrupt Status Register

This block collects up to 32 raw condition inputs into one interrupt status word. It also holds a matching enable mask and drives a single interrupt line. A parameter fixes the type of every bit at build time. A level bit copies its condition and cannot be cleared by software. A rise-event bit latches a 0-to-1 change of its condition. A dual-event bit latches a rising change, a falling change, or both, as its per-bit enables select. A reserved bit is held at zero. The two event kinds stay set until a clearing read.

A shared bus port lets two masters read the status and mask words, and lets them write the mask. A read from the local processor clears every pending event bit. A read from the host processor only observes the bits. One chosen bit position is a summary of a second-level status register. That register's bits arrive on a cascade input and are ORed into a level bit. The interrupt output is the registered OR of all status bits whose mask bit is one.

Top module: `irq_status_reg`

## Requirements
- R1: After a synchronous reset, the status word, the mask word, the read data and `irq` are all zero.
- R2: A level bit (position i with i mod 4 = 0) equals its condition input as sampled at the previous clock edge. Reading the status does not clear it. It drops one clock after its condition goes low.
- R3: A rise-event bit (i mod 4 = 1) is set by a 0-to-1 change of its condition, even when the pulse lasts one clock. It stays set while the condition stays high, and a held-high condition does not set it again once it has been cleared.
- R4: A dual-event bit (i mod 4 = 2) sets on the edges that its rise and fall enables select. With the default enables, bit 6 sets on falling edges only, bit 10 sets on rising edges only, and every other dual bit sets on both edges.
- R5: A status read (address 0) with `bus_src` = 0 (local) returns the value the status word held before the read, on `bus_rdata` one clock later. The same read clears every event and dual-event bit.
- R6: A status read with `bus_src` = 1 (host) returns the status word and leaves every bit unchanged.
- R7: When a qualifying edge arrives in the same clock as a clearing local read, the bit stays set after that read.
- R8: Reserved positions (i mod 4 = 3) always read as zero and never assert `irq`, whatever their condition inputs and mask bits are.
- R9: Bit 8 is a level summary bit. It equals the OR of `casc_in` as sampled at the previous edge, it ignores `cond_in[8]`, and a read does not clear it.
- R10: The mask is written at address 1 and reads back there. `irq` is the OR of status ANDed with mask, registered, so it changes one clock after the status or the mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_in | input | 32 | Raw condition inputs, one per status bit |
| casc_in | input | 8 | Status bits of the second-level register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_src | input | 1 | Master of the access: 0 local, 1 host |
| bus_addr | input | 2 | Word address: 0 status, 1 mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one clock after the read |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its defaults: 32 bits, an 8-bit cascade, summary at bit 8, and the type pattern level, rise, dual, reserved repeated every four bits. With these defaults, every bit type appears at known positions. The two asymmetric dual bits (6 and 10) make rise-only and fall-only behaviour observable next to the both-edge case. Because the summary bit sits on a position whose pattern type is level, the test can show that its own condition input is ignored.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  // Per-bit behaviour, selected at build time.
  typedef enum logic [1:0] {
    BT_RSVD  = 2'd0,
    BT_LEVEL = 2'd1,
    BT_RISE  = 2'd2,
    BT_DUAL  = 2'd3
  } bit_type_e;

  // Master encoding on the bus.
  localparam logic SRC_LOCAL = 1'b0;
  localparam logic SRC_HOST  = 1'b1;

endpackage

// File: rtl/irq_bit_cell.sv
module irq_bit_cell
  import irq_stat_pkg::*;
#(
  parameter bit_type_e TYPE    = BT_LEVEL,
  parameter logic      RISE_EN = 1'b1,
  parameter logic      FALL_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  input  logic clr,
  output logic stat
);

  logic prev_q;
  logic stat_q;
  logic stat_d;
  logic rise_ev;
  logic fall_ev;
  logic set_ev;

  assign rise_ev = cond & ~prev_q;
  assign fall_ev = ~cond & prev_q;

  always_comb begin
    set_ev = 1'b0;
    stat_d = 1'b0;
    case (TYPE)
      BT_LEVEL: stat_d = cond;
      BT_RISE: begin
        set_ev = rise_ev;
        stat_d = set_ev | (stat_q & ~clr);
      end
      BT_DUAL: begin
        set_ev = (RISE_EN & rise_ev) | (FALL_EN & fall_ev);
        stat_d = set_ev | (stat_q & ~clr);
      end
      default: stat_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= cond;
      stat_q <= stat_d;
    end
  end

  assign stat = stat_q;

  generate
    if (TYPE == BT_LEVEL) begin : g_lvl_chk
      // R2: level bit tracks the previous sample of its condition
      a_r2_level_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat_q == $past(cond)));
    end else if (TYPE == BT_RISE || TYPE == BT_DUAL) begin : g_evt_chk
      // R3, R4: a selected edge latches the bit
      a_r3_edge_sets: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> stat_q);
      // R3: without a clearing read the bit holds
      a_r3_holds: assert property (@(posedge clk) disable iff (rst)
        (stat_q && !clr) |=> stat_q);
      // R5: clearing read without a new edge empties the bit
      a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_ev) |=> !stat_q);
    end
  endgenerate

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);

  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)     mask_q <= '0;
    else if (we) mask_q <= wdata;
  end

  assign mask = mask_q;

  // R10: a write lands in the mask on the next edge
  a_r10_mask_write: assert property (@(posedge clk) disable iff (rst)
    we |=> (mask_q == $past(wdata)));

endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port
  import irq_stat_pkg::*;
#(
  parameter int           W         = 32,
  parameter int           AW        = 2,
  parameter logic [AW-1:0] ADDR_STAT = '0,
  parameter logic [AW-1:0] ADDR_MASK = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic          wr,
  input  logic          src,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  stat,
  input  logic [W-1:0]  mask,
  output logic [W-1:0]  rdata,
  output logic          clr_req,
  output logic          mask_we
);

  logic [W-1:0] rd_mux;
  logic [W-1:0] rdata_q;

  assign clr_req = rd && (addr == ADDR_STAT) && (src == SRC_LOCAL);
  assign mask_we = wr && (addr == ADDR_MASK);

  always_comb begin
    if (addr == ADDR_STAT)      rd_mux = stat;
    else if (addr == ADDR_MASK) rd_mux = mask;
    else                        rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;

  // R5: a status read returns the word held in the read cycle
  a_r5_read_value: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADDR_STAT) |=> (rdata_q == $past(stat)));

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_stat_pkg::*;
#(
  parameter int              W            = 32,
  parameter int              CASC_W       = 8,
  parameter int              AW           = 2,
  parameter int              SUM_IDX      = 8,
  parameter logic [2*W-1:0]  BIT_TYPES    = 64'h3939_3939_3939_3939,
  parameter logic [W-1:0]    DUAL_RISE_EN = 32'hFFFF_FFBF,
  parameter logic [W-1:0]    DUAL_FALL_EN = 32'hFFFF_FBFF,
  parameter logic [AW-1:0]   ADDR_STAT    = 0,
  parameter logic [AW-1:0]   ADDR_MASK    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      cond_in,
  input  logic [CASC_W-1:0] casc_in,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_src,
  input  logic [AW-1:0]     bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq
);

  logic [W-1:0] stat_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] rsvd_bits;
  logic [W-1:0] evt_bits;
  logic         clr_req;
  logic         mask_we;
  logic         casc_any;
  logic         irq_q;

  assign casc_any = |casc_in;

  generate
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
      localparam bit_type_e TY = (gi == SUM_IDX) ? BT_LEVEL
                                 : bit_type_e'(BIT_TYPES[2*gi +: 2]);
      logic src_cond;

      assign src_cond      = (gi == SUM_IDX) ? casc_any : cond_in[gi];
      assign rsvd_bits[gi] = (TY == BT_RSVD);
      assign evt_bits[gi]  = (TY == BT_RISE) || (TY == BT_DUAL);

      irq_bit_cell #(
        .TYPE    (TY),
        .RISE_EN (DUAL_RISE_EN[gi]),
        .FALL_EN (DUAL_FALL_EN[gi])
      ) u_cell (
        .clk  (clk),
        .rst  (rst),
        .cond (src_cond),
        .clr  (clr_req),
        .stat (stat_q[gi])
      );
    end
  endgenerate

  irq_mask_reg #(.W(W)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .we    (mask_we),
    .wdata (bus_wdata),
    .mask  (mask_q)
  );

  irq_bus_port #(
    .W         (W),
    .AW        (AW),
    .ADDR_STAT (ADDR_STAT),
    .ADDR_MASK (ADDR_MASK)
  ) u_port (
    .clk     (clk),
    .rst     (rst),
    .rd      (bus_rd),
    .wr      (bus_wr),
    .src     (bus_src),
    .addr    (bus_addr),
    .stat    (stat_q),
    .mask    (mask_q),
    .rdata   (bus_rdata),
    .clr_req (clr_req),
    .mask_we (mask_we)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_q & mask_q);
  end

  assign irq = irq_q;

  // R6: a host status read leaves every pending event bit set
  a_r6_host_keeps: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_STAT && bus_src == SRC_HOST)
    |=> ((stat_q & evt_bits & $past(stat_q)) == ($past(stat_q) & evt_bits)));

  // R8: reserved positions never appear on the read data
  a_r8_rsvd_rdata: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & rsvd_bits) == '0);

  // R9: summary bit follows the cascade OR
  a_r9_summary: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_q[SUM_IDX] == $past(casc_any)));

  // R10: interrupt is the registered masked OR
  a_r10_irq_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_q == |($past(stat_q & mask_q))));

endmodule

// File: tb/irq_status_reg_tb.sv
module irq_status_reg_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] cond_in;
  logic [7:0]  casc_in;
  logic        bus_rd, bus_wr, bus_src;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_status_reg u_dut (
    .clk(clk), .rst(rst), .cond_in(cond_in), .casc_in(casc_in),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_src(bus_src),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_word(input logic src, input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_src = src; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr_mask(input logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_cond(input logic [31:0] v);
    @(negedge clk);
    cond_in = v;
  endtask

  task automatic quiesce();
    logic [31:0] d;
    set_cond(32'h0);
    casc_in = 8'h0;
    wr_mask(32'h0);
    repeat (2) @(negedge clk);
    rd_word(1'b0, 2'd0, d);
    rd_word(1'b0, 2'd0, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd_word(1'b1, 2'd0, d); chk("R1 status", d, 32'h0);
    rd_word(1'b1, 2'd1, d); chk("R1 mask", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    set_cond(32'h1);
    rd_word(1'b0, 2'd0, d); chk("R2 level set", d, 32'h1);
    rd_word(1'b0, 2'd0, d); chk("R2 level not cleared by read", d, 32'h1);
    set_cond(32'h0);
    rd_word(1'b0, 2'd0, d); chk("R2 level drops", d, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    set_cond(32'h2); set_cond(32'h0);
    rd_word(1'b0, 2'd0, d); chk("R3 one-clock pulse latched", d, 32'h2);
    rd_word(1'b0, 2'd0, d); chk("R5 local read cleared", d, 32'h0);
    set_cond(32'h2);
    rd_word(1'b0, 2'd0, d); chk("R3 held high set", d, 32'h2);
    rd_word(1'b0, 2'd0, d); chk("R3 cleared", d, 32'h0);
    rd_word(1'b0, 2'd0, d); chk("R3 no re-set while high", d, 32'h0);
    set_cond(32'h0);
  endtask

  task automatic t_dual();
    logic [31:0] d;
    set_cond(32'h4);
    rd_word(1'b0, 2'd0, d); chk("R4 bit2 rise", d, 32'h4);
    rd_word(1'b0, 2'd0, d); chk("R4 bit2 cleared", d, 32'h0);
    set_cond(32'h0);
    rd_word(1'b0, 2'd0, d); chk("R4 bit2 fall", d, 32'h4);
    rd_word(1'b0, 2'd0, d); chk("R4 bit2 cleared again", d, 32'h0);
    set_cond(32'h40);
    rd_word(1'b0, 2'd0, d); chk("R4 bit6 ignores rise", d, 32'h0);
    set_cond(32'h0);
    rd_word(1'b0, 2'd0, d); chk("R4 bit6 fall", d, 32'h40);
    set_cond(32'h400);
    rd_word(1'b0, 2'd0, d); chk("R4 bit10 rise", d, 32'h400);
    set_cond(32'h0);
    rd_word(1'b0, 2'd0, d); chk("R4 bit10 ignores fall", d, 32'h0);
  endtask

  task automatic t_host();
    logic [31:0] d;
    set_cond(32'h20); set_cond(32'h0);
    rd_word(1'b1, 2'd0, d); chk("R6 host read sees bit5", d, 32'h20);
    rd_word(1'b1, 2'd0, d); chk("R6 host read kept bit5", d, 32'h20);
    rd_word(1'b0, 2'd0, d); chk("R5 local read value", d, 32'h20);
    rd_word(1'b0, 2'd0, d); chk("R5 local read cleared bit5", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    set_cond(32'h2); set_cond(32'h0);
    @(negedge clk);
    cond_in = 32'h2; bus_rd = 1'b1; bus_src = 1'b0; bus_addr = 2'd0;
    @(negedge clk);
    bus_rd = 1'b0; cond_in = 32'h0;
    chk("R7 read during edge returns set", bus_rdata, 32'h2);
    rd_word(1'b0, 2'd0, d); chk("R7 bit kept after collision", d, 32'h2);
    rd_word(1'b0, 2'd0, d); chk("R7 later read clears", d, 32'h0);
  endtask

  task automatic t_rsvd();
    logic [31:0] d;
    set_cond(32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    rd_word(1'b1, 2'd0, d); chk("R8 reserved read zero", d, 32'h7777_7637);
    wr_mask(32'h8888_8888);
    repeat (2) @(negedge clk);
    chk("R8 reserved never raise irq", {31'h0, irq}, 32'h0);
    wr_mask(32'hFFFF_FFFF);
    @(negedge clk);
    chk("R10 full mask raises irq", {31'h0, irq}, 32'h1);
    quiesce();
  endtask

  task automatic t_casc();
    logic [31:0] d;
    set_cond(32'h100);
    rd_word(1'b0, 2'd0, d); chk("R9 own cond ignored", d, 32'h0);
    set_cond(32'h0);
    casc_in = 8'h10;
    rd_word(1'b1, 2'd0, d); chk("R9 summary set", d, 32'h100);
    rd_word(1'b0, 2'd0, d); chk("R9 summary read", d, 32'h100);
    rd_word(1'b0, 2'd0, d); chk("R9 summary not cleared by read", d, 32'h100);
    @(negedge clk); casc_in = 8'h0;
    rd_word(1'b0, 2'd0, d); chk("R9 summary drops", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr_mask(32'h2);
    rd_word(1'b1, 2'd1, d); chk("R10 mask readback", d, 32'h2);
    set_cond(32'h2); set_cond(32'h0);
    chk("R10 irq not yet", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 irq one clock later", {31'h0, irq}, 32'h1);
    @(negedge clk);
    bus_rd = 1'b1; bus_src = 1'b0; bus_addr = 2'd0;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R10 irq still high at clear edge", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R5 irq drops after clear", {31'h0, irq}, 32'h0);
    set_cond(32'h2); set_cond(32'h0);
    @(negedge clk);
    chk("R10 irq again", {31'h0, irq}, 32'h1);
    wr_mask(32'h0);
    chk("R10 irq lags mask write", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R10 irq off after mask cleared", {31'h0, irq}, 32'h0);
    quiesce();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cond_in = '0; casc_in = '0;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_src = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_level();
    t_rise();
    t_dual();
    t_host();
    t_collide();
    t_rsvd();
    t_casc();
    t_irq();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule